// File: doc/BRIEF.md
# Serial Reader for a Register-less Sigma-Delta Converter

This block is the host-side controller for a sigma-delta converter that has no command path: the host only selects it, supplies the serial clock and reads results. One input line serves two purposes. When the line is pulled low, a conversion is waiting. The same line then carries the result bits, one per serial clock pulse. The block holds the converter selected while `en` is high. It waits for the ready-low, clocks in one word with MSB first, waits for the line to return high, and then reports the word as a signed two's-complement value together with a one-cycle strobe.

The converter delivers offset-binary words. The block inverts the most significant bit to get two's complement. The converter needs time to settle after each wake-up, so the first `DISCARD` words after every enable are read and dropped. A watchdog raises `timeout` if no ready-low arrives within about one and a half update periods while the block is waiting. By default, the serial clock divider and the watchdog limit are derived from the system clock frequency, the minimum serial clock phase time and the nominal update period.

Top module: `sd_adc_reader`

## Requirements
- R1: After reset with `en` low, `cs_n` is 1, `sclk` is 1, `sample_vld` is 0 and `timeout` is 0.
- R2: `cs_n` falls within two clock cycles of `en` rising and rises within two cycles of `en` falling. While `en` is low, a low level on `rdy_dout` produces no `sclk` pulse and no `sample_vld`.
- R3: Each read is started by a low on `rdy_dout` (seen through `SYNC_STAGES` synchronizer flops) and produces exactly `WORD_W` falling edges on `sclk`. Between reads and while deselected, `sclk` rests at 1.
- R4: Every low phase and every high phase of `sclk` lasts at least `HALF_DIV` system clock cycles.
- R5: Bits are taken MSB first. Each bit is captured as `sclk` rises, after the converter has changed the line on the preceding falling edge.
- R6: `sample` equals the received word with its MSB inverted, giving two's complement. Raw 0x000000 gives 0x800000, raw 0x800000 gives 0x000000, and raw 0xFFFFFF gives 0x7FFFFF.
- R7: The first `DISCARD` words read after each enable produce no `sample_vld`. Every later word produces exactly one.
- R8: `sample_vld` is a single-cycle pulse. It comes no later than `HALF_DIV`+`SYNC_STAGES`+4 cycles after the final rising edge of `sclk`, provided the line is back high by then. `sample` changes only in a cycle where `sample_vld` is 1.
- R9: While enabled and waiting, `timeout` rises once `TIMEOUT_CYC` cycles have passed with no ready-low. It clears when a read starts or when `en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | 1 keeps the converter selected and awake; 0 powers it down |
| rdy_dout | input | 1 | Shared ready-flag / serial data line from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sample | output | WORD_W | Last reported result, two's complement |
| sample_vld | output | 1 | One-cycle strobe when `sample` is updated |
| timeout | output | 1 | No ready-low within the watchdog window |

## Verification
The select line follows `en` one register later, so the bench samples it on the second falling clock edge after toggling `en`. A result is due a few cycles after the last rising `sclk` edge: one full high phase, one cycle for the read engine to report, and one for the controller to register the output. The bench therefore waits `HALF_DIV`+`SYNC_STAGES`+10 cycles after each frame before it counts strobes and `sclk` falls. It also records the exact distance from the last rising edge to each strobe and bounds it. The watchdog is probed 50 cycles before and 50 cycles after its limit, which keeps the margin well away from the few cycles spent in the synchronizer and the controller.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

   typedef enum logic [1:0] {
      CT_OFF,
      CT_WAIT,
      CT_READ,
      CT_RELEASE
   } ctl_state_t;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LOW,
      SH_HIGH
   } sh_state_t;

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("sdr_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= RESET_VAL;
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RESET_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sdr_shift_engine.sv
module sdr_shift_engine
   import sdr_pkg::*;
#(
   parameter int unsigned WORD_W   = 24,
   parameter int unsigned HALF_DIV = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              din,
   output logic              sclk,
   output logic              done,
   output logic [WORD_W-1:0] word
);

   localparam int unsigned PH_W  = $clog2(HALF_DIV + 1);
   localparam int unsigned BIT_W = $clog2(WORD_W + 1);

   if (HALF_DIV < 2) begin : g_bad_half
      $error("sdr_shift_engine: HALF_DIV must be at least 2");
   end

   sh_state_t         st;
   logic [PH_W-1:0]   ph;
   logic [BIT_W-1:0]  nbits;
   logic [WORD_W-1:0] shreg;
   logic              ph_end;

   assign ph_end = (ph == PH_W'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SH_IDLE;
         ph    <= '0;
         nbits <= '0;
         shreg <= '0;
         done  <= 1'b0;
         sclk  <= 1'b1;
      end else begin
         done <= 1'b0;
         if (abort) begin
            st    <= SH_IDLE;
            ph    <= '0;
            nbits <= '0;
            sclk  <= 1'b1;
         end else begin
            case (st)
               SH_IDLE: begin
                  if (start) begin
                     st    <= SH_LOW;
                     sclk  <= 1'b0;
                     ph    <= '0;
                     nbits <= '0;
                  end
               end
               SH_LOW: begin
                  if (ph_end) begin
                     shreg <= {shreg[WORD_W-2:0], din};
                     st    <= SH_HIGH;
                     sclk  <= 1'b1;
                     ph    <= '0;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               SH_HIGH: begin
                  if (ph_end) begin
                     ph <= '0;
                     if (nbits == BIT_W'(WORD_W - 1)) begin
                        st    <= SH_IDLE;
                        nbits <= '0;
                        done  <= 1'b1;
                     end else begin
                        nbits <= nbits + 1'b1;
                        st    <= SH_LOW;
                        sclk  <= 1'b0;
                     end
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               default: st <= SH_IDLE;
            endcase
         end
      end
   end

   assign word = shreg;

   // Checker state: length of the current sclk level, saturating.
   logic            sclk_prev;
   logic [PH_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b1;
         hold      <= '0;
      end else begin
         sclk_prev <= sclk;
         if (sclk != sclk_prev)            hold <= '0;
         else if (hold != PH_W'(HALF_DIV)) hold <= hold + 1'b1;
      end
   end

   // R4: a level of sclk lasts at least HALF_DIV cycles before changing
   p_phase_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((sclk != sclk_prev) && !$past(abort)) |-> (hold >= PH_W'(HALF_DIV - 1)));

   // R3: the bit counter never reaches the word width
   p_bits_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nbits < BIT_W'(WORD_W));

endmodule

// File: rtl/sdr_watchdog.sv
module sdr_watchdog #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expired
);

   localparam int unsigned CNT_W = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("sdr_watchdog: LIMIT must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (!arm) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (cnt == CNT_W'(LIMIT - 1)) begin
         expired <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9: disarming always clears the flag on the next cycle
   p_clear_on_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !expired);

endmodule

// File: rtl/sd_adc_reader.sv
module sd_adc_reader
   import sdr_pkg::*;
#(
   parameter int unsigned WORD_W       = 24,
   parameter int unsigned CLK_HZ       = 50_000_000,
   parameter int unsigned MIN_PHASE_NS = 100,
   parameter int unsigned UPDATE_US    = 50_540,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned DISCARD      = 1,
   parameter int unsigned HALF_DIV     =
      int'((64'(CLK_HZ) * 64'(MIN_PHASE_NS) + 64'd999_999_999) / 64'd1_000_000_000),
   parameter int unsigned TIMEOUT_CYC  =
      int'((64'(CLK_HZ) * 64'(UPDATE_US) * 64'd3) / 64'd2_000_000)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     rdy_dout,
   output logic                     cs_n,
   output logic                     sclk,
   output logic signed [WORD_W-1:0] sample,
   output logic                     sample_vld,
   output logic                     timeout
);

   localparam int unsigned DC_W = $clog2(DISCARD + 2);

   if (WORD_W < 2) begin : g_bad_width
      $error("sd_adc_reader: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("sd_adc_reader: SYNC_STAGES must be at least 1");
   end
   if (HALF_DIV < SYNC_STAGES + 1) begin : g_bad_div
      $error("sd_adc_reader: HALF_DIV too short for the synchronizer delay");
   end

   ctl_state_t        st;
   logic              line_s;
   logic              eng_start;
   logic              eng_done;
   logic [WORD_W-1:0] eng_word;
   logic              drop_now;
   logic              frame_end;

   sdr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rdy_dout),
      .q     (line_s)
   );

   assign eng_start = en && (st == CT_WAIT) && !line_s;
   assign frame_end = (st == CT_RELEASE) && line_s;

   sdr_shift_engine #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_engine (
      .clk   (clk),
      .rst_n (rst_n),
      .abort (!en),
      .start (eng_start),
      .din   (line_s),
      .sclk  (sclk),
      .done  (eng_done),
      .word  (eng_word)
   );

   sdr_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (en && (st == CT_WAIT)),
      .expired (timeout)
   );

   if (DISCARD == 0) begin : g_no_discard
      assign drop_now = 1'b0;
   end else begin : g_discard
      logic [DC_W-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     dcnt <= DC_W'(DISCARD);
         else if (st == CT_OFF)          dcnt <= DC_W'(DISCARD);
         else if (frame_end && dcnt != 0) dcnt <= dcnt - 1'b1;
      end
      assign drop_now = (dcnt != 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= CT_OFF;
         cs_n       <= 1'b1;
         sample     <= '0;
         sample_vld <= 1'b0;
      end else begin
         sample_vld <= 1'b0;
         if (!en) begin
            st   <= CT_OFF;
            cs_n <= 1'b1;
         end else begin
            case (st)
               CT_OFF: begin
                  cs_n <= 1'b0;
                  st   <= CT_WAIT;
               end
               CT_WAIT: begin
                  if (!line_s) st <= CT_READ;
               end
               CT_READ: begin
                  if (eng_done) st <= CT_RELEASE;
               end
               CT_RELEASE: begin
                  if (line_s) begin
                     st <= CT_WAIT;
                     if (!drop_now) begin
                        sample_vld <= 1'b1;
                        sample     <= $signed({~eng_word[WORD_W-1], eng_word[WORD_W-2:0]});
                     end
                  end
               end
               default: st <= CT_OFF;
            endcase
         end
      end
   end

   // R1/R3: the converter is never clocked while deselected
   p_idle_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R8: the strobe lasts one cycle
   p_vld_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |=> !sample_vld);

   // R8: the result register moves only together with the strobe
   p_sample_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sample) |-> sample_vld);

   // R7: results are reported only while the converter is selected
   p_vld_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |-> !cs_n);

   // R9: the timeout flag is raised only while selected
   p_timeout_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> !cs_n);

endmodule

// File: tb/tb_sd_adc_reader.sv
module tb_sd_adc_reader;

   localparam int W    = 24;
   localparam int HALF = 5;
   localparam int SYNC = 2;
   localparam int TMO  = 3000;
   localparam int DISC = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic line = 1'b1;
   logic cs_n, sclk, vld, tmo;
   logic signed [W-1:0] sample;

   sd_adc_reader #(
      .WORD_W(W), .SYNC_STAGES(SYNC), .DISCARD(DISC),
      .HALF_DIV(HALF), .TIMEOUT_CYC(TMO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .rdy_dout(line),
      .cs_n(cs_n), .sclk(sclk), .sample(sample),
      .sample_vld(vld), .timeout(tmo)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int falls = 0;
   int vcount = 0;
   int run = 0;
   int min_run = 1_000_000;
   int since_rise = 1_000_000;
   bit finished = 0;
   logic sclk_prev = 1'b1;
   logic vld_prev = 1'b0;
   logic [W-1:0] exp_q[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] to_twos(input logic [W-1:0] raw);
      return raw ^ (1 << (W - 1));
   endfunction

   // Output monitor, sampled on the falling clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk_prev && !sclk) falls++;
         if (sclk != sclk_prev) begin
            if (!cs_n && run < min_run) min_run = run;
            run = 1;
         end else begin
            run++;
         end
         if (!sclk_prev && sclk) since_rise = 0;
         else                    since_rise++;
         if (vld) begin
            vcount++;
            chk(!vld_prev, "R8 strobe width", 1, 0);
            chk(since_rise <= HALF + SYNC + 4, "R8 latency", since_rise, HALF + SYNC + 4);
            if (exp_q.size() == 0) begin
               chk(0, "R7 unexpected strobe", sample, 0);
            end else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(sample == e, "R6 value (R5 bit order)", sample, e);
            end
         end
         sclk_prev = sclk;
         vld_prev  = vld;
      end
   end

   int since_en = 0;

   task automatic send(input logic [W-1:0] w);
      int f0, v0;
      bit expect_out;
      expect_out = (since_en >= DISC);
      f0 = falls;
      v0 = vcount;
      if (expect_out) exp_q.push_back(to_twos(w));
      @(negedge clk);
      line = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         @(negedge sclk);
         #1 line = w[i];
      end
      @(posedge sclk);
      #1 line = 1'b1;
      repeat (HALF + SYNC + 10) @(negedge clk);
      chk(falls - f0 == W, "R3 pulse count", falls - f0, W);
      chk(sclk == 1'b1, "R3 idle level", sclk, 1);
      chk(vcount - v0 == int'(expect_out), "R7 strobe count", vcount - v0, expect_out);
      since_en++;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int f0, v0;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
      chk(sclk == 1'b1, "R1 sclk", sclk, 1);
      chk(vld == 1'b0, "R1 strobe", vld, 0);
      chk(tmo == 1'b0, "R1 timeout", tmo, 0);

      // R2: ready-low ignored while disabled
      f0 = falls; v0 = vcount;
      line = 1'b0;
      repeat (40) @(negedge clk);
      chk(falls == f0, "R2 no clock when disabled", falls - f0, 0);
      chk(vcount == v0, "R2 no strobe when disabled", vcount - v0, 0);
      line = 1'b1;
      repeat (5) @(negedge clk);

      en = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n == 1'b0, "R2 select on enable", cs_n, 0);
      since_en = 0;
      repeat (10) @(negedge clk);

      send(24'h123456);          // R7 dropped
      send(24'h000000);          // R6 -> 0x800000
      send(24'h800000);          // R6 -> 0x000000
      send(24'hFFFFFF);          // R6 -> 0x7FFFFF
      send(24'h7FFFFF);
      send(24'h000001);
      for (int k = 0; k < 10; k++) begin
         logic [31:0] r;
         repeat ($urandom_range(3, 40)) @(negedge clk);
         r = $urandom;
         send(r[W-1:0]);
      end

      // R9 watchdog
      repeat (TMO - 50) @(negedge clk);
      chk(tmo == 1'b0, "R9 early", tmo, 0);
      repeat (100) @(negedge clk);
      chk(tmo == 1'b1, "R9 expired", tmo, 1);
      send(24'h5A5A5A);
      chk(tmo == 1'b0, "R9 cleared by read", tmo, 0);

      // R2 disable
      repeat (20) @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      chk(cs_n == 1'b1, "R2 deselect", cs_n, 1);
      chk(sclk == 1'b1, "R3 idle when off", sclk, 1);
      f0 = falls; v0 = vcount;
      line = 1'b0;
      repeat (40) @(negedge clk);
      chk(falls == f0, "R2 ignored line", falls - f0, 0);
      chk(vcount == v0, "R2 ignored strobe", vcount - v0, 0);
      line = 1'b1;
      repeat (5) @(negedge clk);

      // R7 re-enable discards again
      en = 1'b1;
      since_en = 0;
      repeat (10) @(negedge clk);
      send(24'hABCDEF);
      send(24'h00FF00);

      chk(min_run >= HALF, "R4 phase length", min_run, HALF);
      chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule